// File: doc/BRIEF.md
# Interrupt request masking front end

This block sits at the entry of an interrupt controller. It samples a bank of level-sensitive hardware request lines on every clock and merges them with software-raised requests held in a register. It then gates the merged requests with a per-source enable and steers each surviving request to one of two classes: the normal interrupt class (IRQ) or the fast interrupt class (FIQ).

Three results leave the block: the per-source IRQ request vector, the per-source FIQ request vector, and one combined non-vectored IRQ line. The combined line is the OR of the IRQ-class requests that no enabled vector slot has claimed. Vector slots report their claims back on a claim input. Slot matching, priority and vector addresses live downstream.

Control goes through a plain register port. The port has a valid strobe, a write flag, an address and write data, and returns read data combinationally. Enables and software requests have separate set and clear addresses, so that software never has to do a read-modify-write.

Top module: `irq_mask_front`

## Requirements
- R1: Each hardware source line is sampled into a register on every rising clock edge. Raw status (address 0x0) reads that sampled value ORed with the software request register. A change on a source line shows in raw status and in the request outputs after the next rising edge.
- R2: A write to address 0x6 sets every software request bit whose write-data bit is 1, and 0 bits leave the register unchanged. A software request is treated exactly like a hardware request of the same source, and address 0x6 reads the software request register.
- R3: A write to address 0x7 clears every software request bit whose write-data bit is 1, and 0 bits leave the register unchanged. Address 0x7 also reads the software request register.
- R4: A source raises an IRQ or FIQ request only while its enable bit is 1.
- R5: Address 0x3 holds the class select register, read and written as a whole word. An enabled request goes to `fiq_req_o` when its select bit is 1 and to `irq_req_o` when it is 0, and never to both.
- R6: A write to address 0x4 sets the enable bits that are 1 in the write data. A write to address 0x5 clears the enable bits that are 1 in the write data. Bits written as 0 have no effect at either address, and both addresses read the enable register.
- R7: `nv_irq_o` is 1 exactly when some bit of `irq_req_o` is 1 while the same bit of `claim_i` is 0.
- R8: Address 0x1 reads the IRQ request vector and address 0x2 reads the FIQ request vector. Reads have no side effects. Writes to 0x0, 0x1, 0x2 and 0x8 to 0xF change nothing. Reads of 0x8 to 0xF return 0. `reg_rdata_o` is 0 whenever no read is being presented.
- R9: A synchronous active-high reset clears the enable, select and software request registers and the sampled source lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level-sensitive hardware request lines |
| claim_i | input | N_SRC | Per-source claim from enabled vector slots |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | N_SRC | Write data, one bit per source |
| reg_rdata_o | output | N_SRC | Combinational read data |
| irq_req_o | output | N_SRC | Masked IRQ-class requests |
| fiq_req_o | output | N_SRC | Masked FIQ-class requests |
| nv_irq_o | output | 1 | Combined unclaimed IRQ request |

## Verification
On an 8-source build, the bench walks every source pattern under enables of none, all and an alternating mix. These patterns separate a missing mask from a wrong bit position. Each enable setting is combined with select words of all-IRQ, all-FIQ and half-split, which exposes inverted or crossed class routing. Each of those runs is repeated with no claims and with an alternating claim mask, so the combined line has to follow only unclaimed IRQ bits. One pass keeps software requests set, which shows that they merge ahead of the mask. Directed register sequences write zeros, overlapping sets and clears, and writes to read-only and unmapped addresses.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_RAW   = 4'h0,
        A_IRQST = 4'h1,
        A_FIQST = 4'h2,
        A_CLASS = 4'h3,
        A_ENSET = 4'h4,
        A_ENCLR = 4'h5,
        A_SWSET = 4'h6,
        A_SWCLR = 4'h7
    } reg_addr_e;

    typedef struct packed {
        logic      valid;
        logic      write;
        reg_addr_e addr;
    } port_ctl_t;

    function automatic logic wr_hit(port_ctl_t c, reg_addr_e target);
        return c.valid && c.write && (c.addr == target);
    endfunction

    function automatic logic rd_on(port_ctl_t c);
        return c.valid && !c.write;
    endfunction

endpackage

// File: rtl/irqm_regs.sv
module irqm_regs
    import irqm_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  port_ctl_t        ctl,
    input  logic [N_SRC-1:0] wdata,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] src_q,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] class_q,
    output logic [N_SRC-1:0] sw_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            en_q    <= '0;
            class_q <= '0;
            sw_q    <= '0;
        end else begin
            src_q <= src_i;
            if (wr_hit(ctl, A_CLASS)) class_q <= wdata;
            if (wr_hit(ctl, A_ENSET)) en_q    <= en_q | wdata;
            if (wr_hit(ctl, A_ENCLR)) en_q    <= en_q & ~wdata;
            if (wr_hit(ctl, A_SWSET)) sw_q    <= sw_q | wdata;
            if (wr_hit(ctl, A_SWCLR)) sw_q    <= sw_q & ~wdata;
        end
    end

    // R6: bits written 1 to the set address are enabled afterwards
    assert_enset_R6: assert property (@(posedge clk) disable iff (rst)
        wr_hit(ctl, A_ENSET) |=> ((en_q & $past(wdata)) == $past(wdata)));

    // R6: bits written 1 to the clear address are disabled afterwards
    assert_enclr_R6: assert property (@(posedge clk) disable iff (rst)
        wr_hit(ctl, A_ENCLR) |=> ((en_q & $past(wdata)) == '0));

    // R3: cleared software bits are gone afterwards
    assert_swclr_R3: assert property (@(posedge clk) disable iff (rst)
        wr_hit(ctl, A_SWCLR) |=> ((sw_q & $past(wdata)) == '0));

    // R2: software bits never drop unless a clear write happened
    assert_swhold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_hit(ctl, A_SWCLR) |=> ((sw_q & $past(sw_q)) == $past(sw_q)));

    // R5: select only moves on a write to its address
    assert_class_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_hit(ctl, A_CLASS) |=> $stable(class_q));

    // R9: reset leaves every register cleared
    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (en_q == '0 && class_q == '0 && sw_q == '0 && src_q == '0));

endmodule

// File: rtl/irqm_route.sv
module irqm_route #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] raw_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] class_i,
    input  logic [N_SRC-1:0] claim_i,
    output logic [N_SRC-1:0] irq_o,
    output logic [N_SRC-1:0] fiq_o,
    output logic             nv_o
);

    logic [N_SRC-1:0] gated;
    logic [N_SRC-1:0] unclaimed;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign gated[g]     = raw_i[g] & en_i[g];
        assign irq_o[g]     = gated[g] & ~class_i[g];
        assign fiq_o[g]     = gated[g] &  class_i[g];
        assign unclaimed[g] = irq_o[g] & ~claim_i[g];
    end

    assign nv_o = |unclaimed;

    // R5: no source is in both classes at once
    assert_class_excl_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_o & fiq_o) == '0);

    // R4: every outgoing request has its enable set
    assert_need_enable_R4: assert property (@(posedge clk) disable iff (rst)
        ((irq_o | fiq_o) & ~en_i) == '0);

    // R7: the combined line implies some IRQ request
    assert_nv_has_irq_R7: assert property (@(posedge clk) disable iff (rst)
        nv_o |-> (irq_o != '0));

endmodule

// File: rtl/irqm_rdmux.sv
module irqm_rdmux
    import irqm_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  port_ctl_t        ctl,
    input  logic [N_SRC-1:0] raw_i,
    input  logic [N_SRC-1:0] irq_i,
    input  logic [N_SRC-1:0] fiq_i,
    input  logic [N_SRC-1:0] class_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] sw_i,
    output logic [N_SRC-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (rd_on(ctl)) begin
            case (ctl.addr)
                A_RAW:            rdata_o = raw_i;
                A_IRQST:          rdata_o = irq_i;
                A_FIQST:          rdata_o = fiq_i;
                A_CLASS:          rdata_o = class_i;
                A_ENSET, A_ENCLR: rdata_o = en_i;
                A_SWSET, A_SWCLR: rdata_o = sw_i;
                default:          rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_mask_front.sv
module irq_mask_front
    import irqm_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [N_SRC-1:0]  claim_i,
    input  logic              reg_valid_i,
    input  logic              reg_write_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [N_SRC-1:0]  reg_wdata_i,
    output logic [N_SRC-1:0]  reg_rdata_o,
    output logic [N_SRC-1:0]  irq_req_o,
    output logic [N_SRC-1:0]  fiq_req_o,
    output logic              nv_irq_o
);

    port_ctl_t        ctl;
    logic [N_SRC-1:0] src_q, en_q, class_q, sw_q, raw;

    assign ctl.valid = reg_valid_i;
    assign ctl.write = reg_write_i;
    assign ctl.addr  = reg_addr_e'(reg_addr_i);

    irqm_regs #(.N_SRC(N_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wdata   (reg_wdata_i),
        .src_i   (src_i),
        .src_q   (src_q),
        .en_q    (en_q),
        .class_q (class_q),
        .sw_q    (sw_q)
    );

    assign raw = src_q | sw_q;

    irqm_route #(.N_SRC(N_SRC)) u_route (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (raw),
        .en_i    (en_q),
        .class_i (class_q),
        .claim_i (claim_i),
        .irq_o   (irq_req_o),
        .fiq_o   (fiq_req_o),
        .nv_o    (nv_irq_o)
    );

    irqm_rdmux #(.N_SRC(N_SRC)) u_rdmux (
        .ctl     (ctl),
        .raw_i   (raw),
        .irq_i   (irq_req_o),
        .fiq_i   (fiq_req_o),
        .class_i (class_q),
        .en_i    (en_q),
        .sw_i    (sw_q),
        .rdata_o (reg_rdata_o)
    );

    // R2: an enabled IRQ-class software request reaches the IRQ output
    assert_sw_reaches_R2: assert property (@(posedge clk) disable iff (rst)
        ((sw_q & en_q & ~class_q & ~irq_req_o) == '0));

    // R1: a sampled source line that is enabled and FIQ-class shows on the FIQ output
    assert_src_reaches_R1: assert property (@(posedge clk) disable iff (rst)
        ((src_q & en_q & class_q & ~fiq_req_o) == '0));

    // R8: no read data without a read strobe
    assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (rst)
        !(reg_valid_i && !reg_write_i) |-> (reg_rdata_o == '0));

endmodule

// File: tb/sim_irq_mask_front.sv
`timescale 1ns/1ps
module sim_irq_mask_front;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src = '0, claim = '0, wdata = '0;
    logic         valid = 1'b0, write = 1'b0;
    logic [3:0]   addr = '0;
    logic [N-1:0] rdata, irq, fiq;
    logic         nv;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_mask_front #(.N_SRC(N)) u0 (
        .clk(clk), .rst(rst), .src_i(src), .claim_i(claim),
        .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_req_o(irq), .fiq_req_o(fiq), .nv_irq_o(nv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        valid = 1; write = 1; addr = a; wdata = d;
        @(negedge clk);
        valid = 0; write = 0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        valid = 1; write = 0; addr = a;
        #0.5;
        d = rdata;
        valid = 0;
        #0.5;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [N-1:0] exp);
        logic [N-1:0] d;
        rd(a, d);
        chk(req, {24'b0, d}, {24'b0, exp});
    endtask

    initial begin
        logic [N-1:0] sw_m, en_l, sel_l, cl_l, e_irq, e_fiq, r;
        logic [N-1:0] en_set [3] = '{8'h00, 8'hFF, 8'hA5};
        logic [N-1:0] sel_set [3] = '{8'h00, 8'hFF, 8'h0F};
        logic [N-1:0] cl_set [2] = '{8'h00, 8'h55};

        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        rdchk("R9 raw", 4'h0, 8'h00);
        rdchk("R9 enable", 4'h4, 8'h00);
        rdchk("R9 select", 4'h3, 8'h00);
        rdchk("R9 swreq", 4'h6, 8'h00);
        chk("R9 irq out", {24'b0, irq}, 0);
        chk("R9 nv out", {31'b0, nv}, 0);

        // R6 enable set/clear
        wr(4'h4, 8'h0F); rdchk("R6 set", 4'h4, 8'h0F);
        wr(4'h4, 8'h00); rdchk("R6 set zeros", 4'h4, 8'h0F);
        wr(4'h5, 8'h03); rdchk("R6 clear", 4'h5, 8'h0C);
        wr(4'h5, 8'h00); rdchk("R6 clear zeros", 4'h4, 8'h0C);
        wr(4'h4, 8'hF0); rdchk("R6 set more", 4'h4, 8'hFC);

        // R2 / R3 software requests
        wr(4'h6, 8'h81); rdchk("R2 swset", 4'h6, 8'h81);
        rdchk("R2 raw merge", 4'h0, 8'h81);
        chk("R2 sw irq", {24'b0, irq}, 32'h80);
        wr(4'h6, 8'h00); rdchk("R2 swset zeros", 4'h6, 8'h81);
        wr(4'h7, 8'h01); rdchk("R3 swclr", 4'h7, 8'h80);
        wr(4'h7, 8'h00); rdchk("R3 swclr zeros", 4'h6, 8'h80);

        // R8 read-only / unmapped writes, side-effect-free reads
        wr(4'h0, 8'hFF); wr(4'h1, 8'hFF); wr(4'h2, 8'hFF); wr(4'h9, 8'hFF);
        rdchk("R8 en kept", 4'h4, 8'hFC);
        rdchk("R8 sel kept", 4'h3, 8'h00);
        rdchk("R8 sw kept", 4'h6, 8'h80);
        rdchk("R8 raw read1", 4'h0, 8'h80);
        rdchk("R8 raw read2", 4'h0, 8'h80);
        rdchk("R8 irq status", 4'h1, 8'h80);
        rdchk("R8 unmapped", 4'hB, 8'h00);
        chk("R8 idle rdata", {24'b0, rdata}, 0);
        wr(4'h7, 8'h80);
        rdchk("R3 swclr last", 4'h6, 8'h00);

        // R1 one-cycle sampling latency
        @(negedge clk);
        src = 8'h55;
        rdchk("R1 before edge", 4'h0, 8'h00);
        @(negedge clk);
        rdchk("R1 after edge", 4'h0, 8'h55);

        // sweep
        for (int pass = 0; pass < 2; pass++) begin
            sw_m = (pass == 1) ? 8'h24 : 8'h00;
            if (pass == 1) wr(4'h6, sw_m);
            for (int ie = 0; ie < 3; ie++) begin
                for (int is = 0; is < 3; is++) begin
                    en_l = en_set[ie]; sel_l = sel_set[is];
                    wr(4'h5, 8'hFF); wr(4'h4, en_l); wr(4'h3, sel_l);
                    rdchk("R5 select rd", 4'h3, sel_l);
                    for (int ic = 0; ic < 2; ic++) begin
                        cl_l = cl_set[ic];
                        claim = cl_l;
                        for (int s = 0; s < 256; s++) begin
                            src = s[N-1:0];
                            @(negedge clk);
                            r = src | sw_m;
                            e_irq = r & en_l & ~sel_l;
                            e_fiq = r & en_l & sel_l;
                            chk("R4 irq", {24'b0, irq}, {24'b0, e_irq});
                            chk("R5 fiq", {24'b0, fiq}, {24'b0, e_fiq});
                            chk("R7 nv", {31'b0, nv}, {31'b0, |(e_irq & ~cl_l)});
                            if (s == 8'hC3) begin
                                rdchk("R1 raw", 4'h0, r);
                                rdchk("R8 fiq status", 4'h2, e_fiq);
                            end
                        end
                    end
                end
            end
        end

        // R9 reset clears again
        wr(4'h4, 8'hFF); wr(4'h6, 8'h3C);
        @(negedge clk); rst = 1; @(negedge clk); rst = 0; src = '0;
        rdchk("R9 re-reset en", 4'h4, 8'h00);
        rdchk("R9 re-reset sw", 4'h6, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule